// File: doc/BRIEF.md
# Bit-Addressable Nonvolatile Store Controller

This block controls a 128-bit nonvolatile store. The store is organised as eight 16-bit words. Word 0 holds the configuration word and words 1 to 7 hold the seven calibration coefficients. The storage array is modelled as flip-flops that keep their contents through the block's own reset.

Only two write operations exist. An erase drives every bit of the store to zero. A bit-set drives one addressed bit to one. Nothing can clear a single bit, so a word is built by erasing the store and then setting its one-bits one at a time. Each write holds the controller busy for a long time given in clock cycles, standing in for the real programming time.

A load request streams all eight words out in order, one word per cycle, so the working registers can be filled before a conversion. A request that arrives while the controller is busy is dropped and raises a sticky error flag.

Top module: `nvs_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `busy`, `err_busy`, `ld_valid` and `ld_done` are all 0.
- R2: An accepted erase (`req_op` = 2'b01) leaves all 128 stored bits at 0.
- R3: An accepted bit-set (`req_op` = 2'b10) sets to 1 the bit `req_bit[3:0]` of word `req_bit[6:4]`, and changes no other bit.
- R4: A bit-set never clears a bit. Setting a bit that is already 1 leaves the store unchanged, and earlier set bits stay set.
- R5: After a bit-set is accepted on a clock edge, `busy` is 1 for exactly PROG_CYCLES cycles and then falls to 0.
- R6: After an erase is accepted on a clock edge, `busy` is 1 for exactly ERASE_CYCLES cycles and then falls to 0.
- R7: A non-NOP request presented while `busy` is 1 does not change the store. It sets `err_busy` on that edge, and `err_busy` then stays 1 until reset.
- R8: After a load (`req_op` = 2'b11) is accepted, `ld_valid` is 1 for eight consecutive cycles. During those cycles `ld_word` counts 0 to 7 and `ld_data` carries that word's stored value. `busy` is 1 throughout.
- R9: `ld_done` is a one-cycle pulse in the cycle after word 7 is presented, and `ld_valid` is 0 in that cycle.
- R10: Stored contents survive a pulse of `rst_n`.
- R11: A NOP request (`req_op` = 2'b00) starts nothing, leaves `busy` at 0 when idle, and never sets `err_busy`, even when it arrives while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the store contents are kept |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Request code: 00 NOP, 01 erase, 10 bit-set, 11 load |
| req_bit | input | 7 | Bit address for a bit-set: [6:4] selects the word, [3:0] the bit |
| busy | output | 1 | An operation is in progress; new requests are refused |
| err_busy | output | 1 | Sticky flag: a request was refused because the controller was busy |
| ld_valid | output | 1 | A load word is presented on `ld_word` and `ld_data` |
| ld_word | output | 3 | Index of the word being presented |
| ld_data | output | 16 | Stored value of the presented word |
| ld_done | output | 1 | One-cycle pulse after the last word of a load |

## Verification
The store can only be observed through a load. A wrong bit in the cell array therefore shows up in `ld_data` on the single cycle that presents the affected word. That is at most eight cycles after the load is accepted, and the check compares every word against a model kept in the bench.

A wrong value in the busy counter shows directly as a `busy` window that is too long or too short. The bench measures that window to the cycle for both write kinds.

A lost or spurious error latch shows on `err_busy` one edge after the offending request. A broken load walker shows as a word index that does not step by one each cycle, or as a missing or misplaced `ld_done` pulse.

// File: rtl/nvs_pkg.sv
// Shared request encoding for the nonvolatile store controller.
// Assumes a 2-bit request code driven by the client on req_op.
package nvs_pkg;
    typedef enum logic [1:0] {
        OP_NOP    = 2'b00,
        OP_ERASE  = 2'b01,
        OP_SETBIT = 2'b10,
        OP_LOAD   = 2'b11
    } nvs_op_e;
endpackage

// File: rtl/nvs_cell_array.sv
// Cell array: WORDS words of WORD_W flip-flops with erase-to-zero and
// set-one-bit writes and one combinational read port.
// Assumes erase_en and set_en are never asserted together.
// The cells have no reset, so a reset pulse leaves the stored contents intact.
module nvs_cell_array #(
    parameter int WORDS  = 8,
    parameter int WORD_W = 16,
    localparam int IDX_W = $clog2(WORDS),
    localparam int BIT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              erase_en,
    input  logic              set_en,
    input  logic [IDX_W-1:0]  set_word,
    input  logic [BIT_W-1:0]  set_bit,
    input  logic [IDX_W-1:0]  rd_word,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] cells [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        // Erase clears the whole word; a set touches only the addressed bit.
        always_ff @(posedge clk) begin
            if (erase_en) begin
                cells[g] <= '0;
            end else if (set_en && (set_word == IDX_W'(g))) begin
                cells[g][set_bit] <= 1'b1;
            end
        end
    end

    // Read port for the load walker.
    assign rd_data = cells[rd_word];
endmodule

// File: rtl/nvs_prog_timer.sv
// Busy timer for writes: loads a cycle count on start and counts down to zero.
// Assumes start is only raised while the timer is idle.
module nvs_prog_timer #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);
    logic [CNT_W-1:0] cnt_q;

    // Down-counter: reload on start, decrement while nonzero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/nvs_load_walker.sv
// Load walker: presents word indexes 0..WORDS-1 on consecutive cycles after
// start, then pulses done for one cycle.
// Assumes start is only raised while the walker is idle.
module nvs_load_walker #(
    parameter int WORDS = 8,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             active,
    output logic [IDX_W-1:0] idx,
    output logic             done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    // Step the index each cycle while active; stop and flag done after the last word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                active <= 1'b1;
                idx    <= '0;
            end else if (active) begin
                if (idx == LAST_IDX) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/nvs_ctrl.sv
// Top of the nonvolatile store controller.
// Accepts erase, bit-set and load requests when idle, and refuses any
// non-NOP request while busy, latching a sticky error flag.
// Assumes the client holds req_* stable around the sampling edge.
module nvs_ctrl #(
    parameter int WORDS        = 8,
    parameter int WORD_W       = 16,
    parameter int PROG_CYCLES  = 12000,
    parameter int ERASE_CYCLES = 12000,
    localparam int IDX_W  = $clog2(WORDS),
    localparam int BIT_W  = $clog2(WORD_W),
    localparam int ADDR_W = IDX_W + BIT_W,
    localparam int MAXCYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES,
    localparam int CNT_W  = $clog2(MAXCYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_bit,
    output logic              busy,
    output logic              err_busy,
    output logic              ld_valid,
    output logic [IDX_W-1:0]  ld_word,
    output logic [WORD_W-1:0] ld_data,
    output logic              ld_done
);
    import nvs_pkg::*;

    nvs_op_e           op;
    logic              accept;
    logic              erase_go;
    logic              set_go;
    logic              load_go;
    logic              prog_busy;
    logic              walk_active;
    logic [IDX_W-1:0]  walk_idx;
    logic [WORD_W-1:0] rd_data;
    logic [CNT_W-1:0]  wr_len;

    // Decode the request and gate it with the busy state.
    always_comb begin
        op       = nvs_op_e'(req_op);
        accept   = req_valid && !busy && (op != OP_NOP);
        erase_go = accept && (op == OP_ERASE);
        set_go   = accept && (op == OP_SETBIT);
        load_go  = accept && (op == OP_LOAD);
        wr_len   = (op == OP_ERASE) ? CNT_W'(ERASE_CYCLES) : CNT_W'(PROG_CYCLES);
    end

    nvs_cell_array #(
        .WORDS (WORDS),
        .WORD_W(WORD_W)
    ) array_i (
        .clk     (clk),
        .erase_en(erase_go),
        .set_en  (set_go),
        .set_word(req_bit[ADDR_W-1:BIT_W]),
        .set_bit (req_bit[BIT_W-1:0]),
        .rd_word (walk_idx),
        .rd_data (rd_data)
    );

    nvs_prog_timer #(
        .CNT_W(CNT_W)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (erase_go || set_go),
        .load_val(wr_len),
        .busy    (prog_busy)
    );

    nvs_load_walker #(
        .WORDS(WORDS)
    ) walker_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (load_go),
        .active(walk_active),
        .idx   (walk_idx),
        .done  (ld_done)
    );

    // Sticky flag for requests refused while busy; cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_busy <= 1'b0;
        end else if (req_valid && busy && (op != OP_NOP)) begin
            err_busy <= 1'b1;
        end
    end

    // Output drive: busy covers both write timing and the load walk.
    assign busy     = prog_busy || walk_active;
    assign ld_valid = walk_active;
    assign ld_word  = walk_idx;
    assign ld_data  = walk_active ? rd_data : '0;
endmodule

// File: rtl/nvs_ctrl_chk.sv
// Assertion checker for nvs_ctrl. It observes the top-level ports only.
// It is attached to every nvs_ctrl instance by the bind below.
module nvs_ctrl_chk #(
    parameter int WORDS = 8,
    parameter int WORD_W = 16,
    parameter int ADDR_W = 7,
    localparam int IDX_W = $clog2(WORDS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [ADDR_W-1:0] req_bit,
    input logic              busy,
    input logic              err_busy,
    input logic              ld_valid,
    input logic [IDX_W-1:0]  ld_word,
    input logic [WORD_W-1:0] ld_data,
    input logic              ld_done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    AST_WRITE_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && (req_op == 2'b01 || req_op == 2'b10)) |=> busy); // R5
    AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(req_valid && req_op != 2'b00)) |=> !busy); // R11
    AST_ERR_ON_REFUSAL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && busy && req_op != 2'b00) |=> err_busy); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_busy |=> err_busy); // R7
    AST_LOAD_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_op == 2'b11) |=> (ld_valid && ld_word == '0)); // R8
    AST_LOAD_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_word != LAST_IDX) |=>
        (ld_valid && ld_word == IDX_W'($past(ld_word) + 1'b1))); // R8
    AST_LOAD_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> busy); // R8
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_word == LAST_IDX) |=> (ld_done && !ld_valid)); // R9
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done |=> !ld_done); // R9
endmodule

bind nvs_ctrl nvs_ctrl_chk #(
    .WORDS (WORDS),
    .WORD_W(WORD_W),
    .ADDR_W(ADDR_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_op   (req_op),
    .req_bit  (req_bit),
    .busy     (busy),
    .err_busy (err_busy),
    .ld_valid (ld_valid),
    .ld_word  (ld_word),
    .ld_data  (ld_data),
    .ld_done  (ld_done)
);

// File: tb/nvs_ctrl_tb_top.sv
module nvs_ctrl_tb_top;
    localparam int PROG  = 6;
    localparam int ERASE = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [6:0]  req_bit = '0;
    logic        busy;
    logic        err_busy;
    logic        ld_valid;
    logic [2:0]  ld_word;
    logic [15:0] ld_data;
    logic        ld_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [15:0] model [8];

    // Vector entry: {op[1:0], bit address[6:0], expected busy cycles[7:0]}
    localparam logic [16:0] VEC [8] = '{
        {2'b01, 7'h00, 8'(ERASE)},
        {2'b10, 7'h00, 8'(PROG)},
        {2'b10, 7'h0F, 8'(PROG)},
        {2'b10, 7'h10, 8'(PROG)},
        {2'b10, 7'h7F, 8'(PROG)},
        {2'b10, 7'h45, 8'(PROG)},
        {2'b10, 7'h45, 8'(PROG)},
        {2'b00, 7'h33, 8'd0}
    };

    always #2.5 clk = ~clk;

    nvs_ctrl #(
        .PROG_CYCLES (PROG),
        .ERASE_CYCLES(ERASE)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_op   (req_op),
        .req_bit  (req_bit),
        .busy     (busy),
        .err_busy (err_busy),
        .ld_valid (ld_valid),
        .ld_word  (ld_word),
        .ld_data  (ld_data),
        .ld_done  (ld_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Present one request across one rising edge; returns 1 ns after that edge.
    task automatic issue(input logic [1:0] op, input logic [6:0] a);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_bit   = a;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        req_op    = 2'b00;
    endtask

    task automatic measure_busy(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(posedge clk);
            #1;
        end
    endtask

    task automatic load_check(input string req);
        issue(2'b11, 7'h00);
        for (int w = 0; w < 8; w++) begin
            chk(ld_valid && busy, "R8", "ld_valid/busy during load", {ld_valid, busy}, 3);
            chk(ld_word == 3'(w), "R8", "ld_word order", ld_word, w);
            chk(ld_data == model[w], req, $sformatf("word %0d content", w), ld_data, model[w]);
            @(posedge clk);
            #1;
        end
        chk(ld_done && !ld_valid, "R9", "done pulse after last word", {ld_done, ld_valid}, 2);
        @(posedge clk);
        #1;
        chk(!ld_done, "R9", "done lasts one cycle", ld_done, 0);
    endtask

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        logic [1:0] op;
        logic [6:0] a;
        for (int w = 0; w < 8; w++) model[w] = '0;

        repeat (3) @(posedge clk);
        #1;
        chk({busy, err_busy, ld_valid, ld_done} == 4'b0, "R1", "outputs in reset",
            {busy, err_busy, ld_valid, ld_done}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk({busy, err_busy, ld_valid, ld_done} == 4'b0, "R1", "outputs after reset",
            {busy, err_busy, ld_valid, ld_done}, 0);

        // Table walk: erase, set bits (including a repeat), NOP; R5, R6, R11 on busy length.
        for (int i = 0; i < 8; i++) begin
            op = VEC[i][16:15];
            a  = VEC[i][14:8];
            issue(op, a);
            measure_busy(n);
            chk(n == int'(VEC[i][7:0]), (op == 2'b01) ? "R6" : (op == 2'b10) ? "R5" : "R11",
                $sformatf("busy length vector %0d", i), n, VEC[i][7:0]);
            if (op == 2'b01) for (int w = 0; w < 8; w++) model[w] = '0;
            if (op == 2'b10) model[a[6:4]][a[3:0]] = 1'b1;
        end
        chk(!err_busy, "R11", "no error from idle traffic", err_busy, 0);
        load_check("R3 R4");

        // Erase clears everything set above.
        issue(2'b01, 7'h00);
        measure_busy(n);
        for (int w = 0; w < 8; w++) model[w] = '0;
        load_check("R2");

        // Refused requests while busy.
        issue(2'b10, 7'h21);
        model[2][1] = 1'b1;
        issue(2'b00, 7'h22);
        chk(!err_busy && busy, "R11", "NOP while busy sets no error", {err_busy, busy}, 1);
        issue(2'b10, 7'h22);
        chk(err_busy, "R7", "error on refused set", err_busy, 1);
        issue(2'b01, 7'h00);
        measure_busy(n);
        chk(err_busy, "R7", "error stays set", err_busy, 1);
        load_check("R7");
        chk(err_busy, "R7", "error still set after load", err_busy, 1);

        // Reset pulse: flags clear, contents kept.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk({busy, err_busy, ld_valid, ld_done} == 4'b0, "R1", "outputs after second reset",
            {busy, err_busy, ld_valid, ld_done}, 0);
        load_check("R10");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule